// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small record of why the chip last came out of reset. Four reset sources each have a sticky flag: power-on, the external reset pin, the watchdog and the debug interface. Each source reports its event to the block as a pulse that lasts one clock cycle. Software reads the flags through a simple register port. It clears them by writing zero to the bits it wants cleared. Once the register has been cleared, the next reset leaves behind only the flag of its own source.

The flags live in a storage domain that only the power-on reset input clears. A system-level reset therefore cannot erase the cause it has just recorded. A power-on event behaves differently from the other sources. It sets its own flag and clears the other three. The power-on flag itself can only be cleared by a software write of zero.

Top module: `rst_cause_status`

## Requirements
- R1: The register sits at address `REG_ADDR` (default 5). Bit 4 is the debug reset flag, bit 3 the watchdog reset flag, bit 1 the external reset flag and bit 0 the power-on flag.
- R2: Bits 7, 6, 5 and 2 always read as zero, and writing ones to them has no effect.
- R3: A pulse on `evt_dbg`, `evt_wdt` or `evt_ext` sets bit 4, 3 or 1 respectively. The flag can be read on the cycle after the pulse and stays set afterwards.
- R4: A pulse on `evt_por` sets bit 0 and clears bits 4, 3 and 1 at the next clock edge.
- R5: A write at `REG_ADDR` clears every implemented flag whose data bit is 0. Flags whose data bit is 1 are left as they were.
- R6: The power-on flag is cleared only by a software write of zero. Debug, watchdog and external events leave it unchanged.
- R7: When a source's event arrives in the same cycle as a clear of its flag, the flag ends up set. The clear can be a software write of zero or the clear caused by a power-on event.
- R8: While `pwr_rst_n` is low, the register reads 0x01 (only the power-on flag is set). This takes effect without waiting for a clock edge.
- R9: A read at any address other than `REG_ADDR` returns zero. A write at any other address leaves the flags unchanged.
- R10: After software clears the register to zero, a single reset event of any source leaves only that source's flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-on-only reset, active low and asynchronous. It loads the value 0x01. |
| evt_por | input | 1 | Power-on event pulse, one cycle long |
| evt_ext | input | 1 | External pin reset event pulse |
| evt_wdt | input | 1 | Watchdog reset event pulse |
| evt_dbg | input | 1 | Debug interface reset event pulse |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | REG_W | Write data. A 0 in an implemented bit clears that flag. |
| bus_rdata | output | REG_W | Read data, combinational; zero when the address does not match |

## Verification
The assertions check on every cycle that the reserved bits stay zero and that each event sets its own flag. They also check that a power-on event leaves exactly the power-on flag when no other event comes with it, that the power-on flag survives anything except a write of zero, and that an address miss reads zero. Some behaviour can only be shown by the bench's scenarios. This covers the full sweep of write values against a fully set register and the sweep of all event combinations with and without a same-cycle clear. It also covers the sequence in which a cleared register is followed by one reset source, and the asynchronous reset value seen while `pwr_rst_n` is still low.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   // Flag positions; software decodes these, so they are fixed.
   localparam int DBG_BIT = 4;
   localparam int WDT_BIT = 3;
   localparam int EXT_BIT = 1;
   localparam int POR_BIT = 0;

   localparam logic [31:0] IMPL_MASK32 =
      (32'd1 << DBG_BIT) | (32'd1 << WDT_BIT) |
      (32'd1 << EXT_BIT) | (32'd1 << POR_BIT);

   // Flags that a power-on event wipes.
   localparam logic [31:0] POR_CLR_MASK32 = IMPL_MASK32 & ~(32'd1 << POR_BIT);
endpackage

// File: rtl/rcs_flag_bit.sv
module rcs_flag_bit #(
   parameter bit IMPL    = 1'b1,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic hw_clr_i,
   input  logic sw_clr_i,
   output logic q_o
);
   generate
      if (IMPL) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= set_i | (q & ~hw_clr_i & ~sw_clr_i);
         end
         assign q_o = q;
      end else begin : g_reserved
         logic unused_in;
         assign unused_in = ^{clk, rst_n, set_i, hw_clr_i, sw_clr_i};
         assign q_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rcs_bus_port.sv
module rcs_bus_port #(
   parameter int ADDR_W = 4,
   parameter int REG_W  = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h5
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic [REG_W-1:0]  flags_i,
   output logic [REG_W-1:0]  sw_clr_o,
   output logic [REG_W-1:0]  bus_rdata
);
   logic hit;
   assign hit       = (bus_addr == REG_ADDR);
   assign sw_clr_o  = (hit && bus_wr) ? ~bus_wdata : '0;
   assign bus_rdata = hit ? flags_i : '0;
endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
   import rcs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int REG_W  = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h5
) (
   input  logic              clk,
   input  logic              pwr_rst_n,
   input  logic              evt_por,
   input  logic              evt_ext,
   input  logic              evt_wdt,
   input  logic              evt_dbg,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata
);
   localparam logic [REG_W-1:0] IMPL_MASK    = REG_W'(IMPL_MASK32);
   localparam logic [REG_W-1:0] POR_CLR_MASK = REG_W'(POR_CLR_MASK32);

   generate
      if (REG_W < DBG_BIT + 1 || REG_W > 32) begin : g_bad_width
         $error("rst_cause_status: REG_W must lie in 5..32");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("rst_cause_status: ADDR_W must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0] flags;
   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] hw_clr_vec;
   logic [REG_W-1:0] sw_clr_vec;

   always_comb begin
      set_vec          = '0;
      set_vec[DBG_BIT] = evt_dbg;
      set_vec[WDT_BIT] = evt_wdt;
      set_vec[EXT_BIT] = evt_ext;
      set_vec[POR_BIT] = evt_por;
   end

   assign hw_clr_vec = evt_por ? POR_CLR_MASK : '0;

   rcs_bus_port #(
      .ADDR_W  (ADDR_W),
      .REG_W   (REG_W),
      .REG_ADDR(REG_ADDR)
   ) u_port (
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .flags_i  (flags),
      .sw_clr_o (sw_clr_vec),
      .bus_rdata(bus_rdata)
   );

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      rcs_flag_bit #(
         .IMPL   (IMPL_MASK[i]),
         .RST_VAL(i == POR_BIT)
      ) u_bit (
         .clk     (clk),
         .rst_n   (pwr_rst_n),
         .set_i   (set_vec[i]),
         .hw_clr_i(hw_clr_vec[i]),
         .sw_clr_i(sw_clr_vec[i]),
         .q_o     (flags[i])
      );
   end
endmodule

// File: rtl/rst_cause_status_chk.sv
module rst_cause_status_chk
   import rcs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int REG_W  = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h5
) (
   input logic              clk,
   input logic              pwr_rst_n,
   input logic              evt_por,
   input logic              evt_ext,
   input logic              evt_wdt,
   input logic              evt_dbg,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  bus_rdata,
   input logic [REG_W-1:0]  flags
);
   localparam logic [REG_W-1:0] RSV_MASK = ~REG_W'(IMPL_MASK32);

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (flags & RSV_MASK) == '0);

   // R3
   ext_set_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      evt_ext |=> flags[EXT_BIT]);

   // R3
   wdt_set_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      evt_wdt |=> flags[WDT_BIT]);

   // R3
   dbg_set_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      evt_dbg |=> flags[DBG_BIT]);

   // R4
   por_only_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (evt_por && !evt_ext && !evt_wdt && !evt_dbg) |=>
         ($countones(flags) == 1 && flags[POR_BIT]));

   // R6
   por_hold_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (flags[POR_BIT] && !(bus_wr && bus_addr == REG_ADDR && !bus_wdata[POR_BIT]))
         |=> flags[POR_BIT]);

   // R9
   miss_read_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (bus_addr != REG_ADDR) |-> (bus_rdata == '0));
endmodule

bind rst_cause_status rst_cause_status_chk #(
   .ADDR_W  (ADDR_W),
   .REG_W   (REG_W),
   .REG_ADDR(REG_ADDR)
) u_chk (
   .clk      (clk),
   .pwr_rst_n(pwr_rst_n),
   .evt_por  (evt_por),
   .evt_ext  (evt_ext),
   .evt_wdt  (evt_wdt),
   .evt_dbg  (evt_dbg),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .flags    (flags)
);

// File: tb/rst_cause_status_test.sv
`timescale 1ns/1ps
module rst_cause_status_test;
   localparam logic [3:0] RA = 4'h5;
   localparam logic [7:0] IMPL = 8'h1B;

   logic       clk = 1'b0;
   logic       pwr_rst_n = 1'b0;
   logic       evt_por = 1'b0, evt_ext = 1'b0, evt_wdt = 1'b0, evt_dbg = 1'b0;
   logic [3:0] bus_addr = RA;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'hFF;
   logic [7:0] bus_rdata;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] exp_v;

   always #2.5 clk = ~clk;

   rst_cause_status uut (
      .clk(clk), .pwr_rst_n(pwr_rst_n),
      .evt_por(evt_por), .evt_ext(evt_ext), .evt_wdt(evt_wdt), .evt_dbg(evt_dbg),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   // Bench model. ev bits: 3=dbg 2=wdt 1=ext 0=por
   function automatic logic [7:0] model(logic [7:0] cur, logic [3:0] ev,
                                        logic hit_wr, logic [7:0] wd);
      logic [7:0] setv, clr;
      setv = {3'b000, ev[3], ev[2], 1'b0, ev[1], ev[0]};
      clr  = hit_wr ? ~wd : 8'h00;
      if (ev[0]) clr = clr | 8'h1A;
      return (setv | (cur & ~clr)) & IMPL;
   endfunction

   task automatic check(string tag, logic [7:0] expv);
      bus_addr = RA; bus_wr = 1'b0;
      #1;
      n_run++;
      if (bus_rdata !== expv) begin
         n_fail++;
         $display("FAIL %s: rdata=%02h expected=%02h", tag, bus_rdata, expv);
      end
   endtask

   // One clock with the given events and bus write, then back to idle.
   task automatic cyc(logic [3:0] ev, logic wr, logic [3:0] a, logic [7:0] wd);
      evt_dbg = ev[3]; evt_wdt = ev[2]; evt_ext = ev[1]; evt_por = ev[0];
      bus_wr = wr; bus_addr = a; bus_wdata = wd;
      @(negedge clk);
      evt_dbg = 0; evt_wdt = 0; evt_ext = 0; evt_por = 0;
      bus_wr = 0; bus_addr = RA; bus_wdata = 8'hFF;
   endtask

   task automatic power_cycle();
      pwr_rst_n = 1'b0;
      @(negedge clk);
      pwr_rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic fill_all();
      power_cycle();
      cyc(4'b1110, 1'b0, RA, 8'hFF);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R8 reset value while held low
      check("R8 reset", 8'h01);
      pwr_rst_n = 1'b1;
      @(negedge clk);
      check("R8 after release", 8'h01);

      // R3/R6: sources that are not power-on keep the power-on flag
      cyc(4'b0010, 1'b0, RA, 8'hFF);
      check("R6 ext keeps por", 8'h03);
      cyc(4'b0100, 1'b0, RA, 8'hFF);
      check("R3 wdt sticky", 8'h0B);
      cyc(4'b1000, 1'b0, RA, 8'hFF);
      @(negedge clk);
      check("R3 dbg sticky", 8'h1B);
      // R4 power-on event clears the others
      cyc(4'b0001, 1'b0, RA, 8'hFF);
      check("R4 por clears others", 8'h01);

      // R10/R1 each source alone after a software clear
      for (int s = 0; s < 4; s++) begin
         logic [3:0] ev;
         ev = 4'(1 << s);
         fill_all();
         cyc(4'b0000, 1'b1, RA, 8'h00);
         check("R5 clear all", 8'h00);
         cyc(ev, 1'b0, RA, 8'hFF);
         check("R10 single source", model(8'h00, ev, 1'b0, 8'hFF));
      end

      // R5/R2 write-value sweep against a fully set register
      for (int w = 0; w < 256; w++) begin
         fill_all();
         cyc(4'b0000, 1'b1, RA, 8'(w));
         check("R5 write sweep", 8'h1B & 8'(w));
      end

      // R2 writing ones to reserved bits from empty
      fill_all();
      cyc(4'b0000, 1'b1, RA, 8'h00);
      cyc(4'b0000, 1'b1, RA, 8'hE4);
      check("R2 reserved ignore", 8'h00);

      // R4/R7 every event combination, with and without a clear in the same cycle
      for (int m = 0; m < 16; m++) begin
         for (int c = 0; c < 2; c++) begin
            logic [7:0] wd;
            wd = (c == 1) ? 8'h00 : 8'hFF;
            fill_all();
            cyc(4'(m), 1'b1, RA, wd);
            check("R7 R4 event combo", model(8'h1B, 4'(m), 1'b1, wd));
         end
      end

      // R9 address sweep, read and write
      for (int a = 0; a < 16; a++) begin
         fill_all();
         bus_addr = 4'(a); #1;
         n_run++;
         exp_v = (4'(a) == RA) ? 8'h1B : 8'h00;
         if (bus_rdata !== exp_v) begin
            n_fail++;
            $display("FAIL R9 read: rdata=%02h expected=%02h", bus_rdata, exp_v);
         end
         @(negedge clk);
         cyc(4'b0000, 1'b1, 4'(a), 8'h00);
         check("R9 write miss", (4'(a) == RA) ? 8'h00 : 8'h1B);
      end

      // R8 asynchronous return to reset value
      fill_all();
      #1 pwr_rst_n = 1'b0;
      #0.5;
      n_run++;
      if (bus_rdata !== 8'h01) begin
         n_fail++;
         $display("FAIL R8 async: rdata=%02h expected=01", bus_rdata);
      end
      @(negedge clk);
      pwr_rst_n = 1'b1;
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule